// File: doc/BRIEF.md
# DAC Register Interface Controller

This block is the digital side of an on-chip voltage-output converter. It sits on a byte-wide register bus and holds three registers: a control byte and the high and low bytes of the conversion code. From them it drives a 12-bit code to the analog converter, a range select, an output-pin select and a power-down line. The analog core and its output buffer are not part of the block.

The code reaches the converter through an output latch. That latch loads only when the low data byte is written. Software can therefore stage the upper bits in the high byte and then commit the whole code with one low-byte write. In 8-bit mode the low byte alone sets the upper eight code bits. A clear control holds both data bytes and the output latch at zero, and an enable control drives the power-down line.

Writes take effect on the rising clock edge on which `bus_wr` is sampled high. Reads are combinational from `bus_addr`.

Top module: `dac_regif`

## Requirements
- R1: After synchronous reset, the control byte, both data bytes and `dac_code` are zero, `pwr_dn` is 1, and `range_sel` and `pin_sel` are 0.
- R2: The low data byte is at address 0xFB, the high data byte is at 0xFC and the control byte is at `CTRL_ADDR` (default 0xFD). A write to any other address changes nothing. A read of any other address returns 0x00.
- R3: The control byte has these fields: bit 4 is the pin select (`pin_sel`), bit 3 is 8-bit mode, bit 2 is the range select (`range_sel`, 1 = supply range), bit 1 is run (0 = hold data cleared), and bit 0 is enable. Bits 7:5 read as 0. `range_sel` and `pin_sel` follow their bits in the cycle after the write.
- R4: `pwr_dn` is the inverse of the enable bit. It changes in the cycle after the control write.
- R5: While the run bit is 0, both data bytes read 0, writes to them are ignored and `dac_code` is 0.
- R6: A high-byte write stores and reads back all 8 bits but does not change `dac_code`.
- R7: In 12-bit mode (bit 3 = 0), a low-byte write sets `dac_code` to {high[3:0], low} in the following cycle.
- R8: In 8-bit mode (bit 3 = 1), a low-byte write sets `dac_code` to {low, 4'b0000} in the following cycle.
- R9: A control write with run = 0 zeroes both data bytes and `dac_code` in the following cycle.
- R10: Changing the mode bit alone leaves `dac_code` unchanged until the next low-byte write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| dac_code | output | 12 | Code presented to the converter |
| range_sel | output | 1 | 1 = supply range, 0 = internal reference range |
| pin_sel | output | 1 | Output pin routing select |
| pwr_dn | output | 1 | Converter power-down |

## Verification
The bench targets three kinds of error.

- **Committing on the wrong write.** A design that commits the code on the high-byte write would show a half-written code. This shows up as a high-byte write that moves `dac_code`.
- **Mapping the code wrongly.** A design that ignores the mode bit, or that remaps the code whenever the mode bit changes, would be caught by mode flips between low-byte writes and by 8-bit loads whose bottom nibble must be zero.
- **Mishandling the clear.** The bench writes data while the run bit is 0 and then releases it. A design that stores those writes, or that zeroes only the data bytes and not the latch, would read back or present stale values.

Writes to unmapped addresses and reserved control bits also check that decode and read-back stay clean.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 12;
    localparam int NIB_W  = CODE_W - BYTE_W;

    // Field order matches control byte bits 4..0
    typedef struct packed {
        logic pin_sel;
        logic mode8;
        logic range_hi;
        logic run;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int RSV_W  = BYTE_W - CTRL_W;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    function automatic ctrl_t ctrl_from_byte(input logic [BYTE_W-1:0] b);
        return ctrl_t'(b[CTRL_W-1:0]);
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        return {{RSV_W{1'b0}}, c};
    endfunction

    function automatic logic [CODE_W-1:0] map_code(input logic mode8,
                                                   input logic [BYTE_W-1:0] lo,
                                                   input logic [NIB_W-1:0] hi_nib);
        if (mode8)
            return {lo, {NIB_W{1'b0}}};
        else
            return {hi_nib, lo};
    endfunction

endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
    import dacif_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LOW_ADDR  = 8'hFB,
    parameter logic [BYTE_W-1:0] HIGH_ADDR = 8'hFC,
    parameter logic [BYTE_W-1:0] CTRL_ADDR = 8'hFD
) (
    input  logic [BYTE_W-1:0] addr,
    output sel_e              sel
);

    always_comb begin
        if (addr == LOW_ADDR)
            sel = SEL_LOW;
        else if (addr == HIGH_ADDR)
            sel = SEL_HIGH;
        else if (addr == CTRL_ADDR)
            sel = SEL_CTRL;
        else
            sel = SEL_NONE;
    end

endmodule

// File: rtl/dacif_ctrl_reg.sv
module dacif_ctrl_reg
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output ctrl_t             ctrl_nxt,
    output logic              pwr_dn
);

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr)
            ctrl_nxt = ctrl_from_byte(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pwr_dn <= 1'b1;
        end else begin
            ctrl_q <= ctrl_nxt;
            if (wr)
                pwr_dn <= ~wdata[0];
        end
    end

    AST_PWR_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
        wr |=> (pwr_dn == !$past(wdata[0])));                               // R4

    AST_PWR_MATCHES_REG: assert property (@(posedge clk) disable iff (rst)
        pwr_dn == !ctrl_q.enable);                                          // R4

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctrl_q));                                           // R3

endmodule

// File: rtl/dacif_data_regs.sv
module dacif_data_regs
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_nxt,
    input  logic              wr_low,
    input  logic              wr_high,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] low_q,
    output logic [BYTE_W-1:0] high_q
);

    always_ff @(posedge clk) begin
        if (rst || !run_nxt) begin
            low_q  <= '0;
            high_q <= '0;
        end else begin
            if (wr_low)
                low_q <= wdata;
            if (wr_high)
                high_q <= wdata;
        end
    end

    AST_DATA_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !run_nxt |=> (low_q == '0 && high_q == '0));                        // R5

    AST_HIGH_STORES: assert property (@(posedge clk) disable iff (rst)
        (wr_high && run_nxt) |=> (high_q == $past(wdata)));                 // R6

endmodule

// File: rtl/dacif_code_latch.sv
module dacif_code_latch
    import dacif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_nxt,
    input  logic              mode8,
    input  logic              load,
    input  logic              wr_high,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic [NIB_W-1:0]  hi_nib,
    output logic [CODE_W-1:0] code_q
);

    always_ff @(posedge clk) begin
        if (rst || !run_nxt)
            code_q <= '0;
        else if (load)
            code_q <= map_code(mode8, lo_in, hi_nib);
    end

    AST_LOAD_12BIT: assert property (@(posedge clk) disable iff (rst)
        (load && run_nxt && !mode8) |=>
            (code_q == {$past(hi_nib), $past(lo_in)}));                     // R7

    AST_LOAD_8BIT: assert property (@(posedge clk) disable iff (rst)
        (load && run_nxt && mode8) |=>
            (code_q[CODE_W-1:NIB_W] == $past(lo_in) && code_q[NIB_W-1:0] == '0)); // R8

    AST_HIGH_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (wr_high && run_nxt) |=> $stable(code_q));                          // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run_nxt |=> (code_q == '0));                                       // R9

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && run_nxt) |=> $stable(code_q));                            // R10

endmodule

// File: rtl/dac_regif.sv
module dac_regif
    import dacif_pkg::*;
#(
    parameter logic [7:0] LOW_ADDR  = 8'hFB,
    parameter logic [7:0] HIGH_ADDR = 8'hFC,
    parameter logic [7:0] CTRL_ADDR = 8'hFD
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic [11:0] dac_code,
    output logic        range_sel,
    output logic        pin_sel,
    output logic        pwr_dn
);

    sel_e              sel;
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_nxt;
    logic [BYTE_W-1:0] low_q;
    logic [BYTE_W-1:0] high_q;
    logic              wr_low;
    logic              wr_high;
    logic              wr_ctrl;

    dacif_decode #(
        .LOW_ADDR (LOW_ADDR),
        .HIGH_ADDR(HIGH_ADDR),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    assign wr_low  = bus_wr && (sel == SEL_LOW);
    assign wr_high = bus_wr && (sel == SEL_HIGH);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);

    dacif_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_ctrl),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .ctrl_nxt(ctrl_nxt),
        .pwr_dn  (pwr_dn)
    );

    dacif_data_regs u_data (
        .clk    (clk),
        .rst    (rst),
        .run_nxt(ctrl_nxt.run),
        .wr_low (wr_low),
        .wr_high(wr_high),
        .wdata  (bus_wdata),
        .low_q  (low_q),
        .high_q (high_q)
    );

    dacif_code_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .run_nxt(ctrl_nxt.run),
        .mode8  (ctrl_q.mode8),
        .load   (wr_low),
        .wr_high(wr_high),
        .lo_in  (bus_wdata),
        .hi_nib (high_q[NIB_W-1:0]),
        .code_q (dac_code)
    );

    always_comb begin
        case (sel)
            SEL_LOW:  bus_rdata = low_q;
            SEL_HIGH: bus_rdata = high_q;
            SEL_CTRL: bus_rdata = ctrl_to_byte(ctrl_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign range_sel = ctrl_q.range_hi;
    assign pin_sel   = ctrl_q.pin_sel;

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (bus_rdata == '0));                           // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_CTRL) |-> (bus_rdata[7:CTRL_W] == '0));                 // R3

    AST_CLEARED_NO_CODE: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.run |-> (dac_code == '0 && low_q == '0 && high_q == '0));   // R5

endmodule

// File: tb/dac_regif_test.sv
module dac_regif_test;

    localparam logic [7:0] A_LOW  = 8'hFB;
    localparam logic [7:0] A_HIGH = 8'hFC;
    localparam logic [7:0] A_CTRL = 8'hFD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [11:0] dac_code;
    logic        range_sel;
    logic        pin_sel;
    logic        pwr_dn;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the register state
    logic [7:0]  m_ctrl = 8'h00;
    logic [7:0]  m_low  = 8'h00;
    logic [7:0]  m_high = 8'h00;
    logic [11:0] m_code = 12'h000;

    always #2.5 clk = ~clk;

    dac_regif uut (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .dac_code (dac_code),
        .range_sel(range_sel),
        .pin_sel  (pin_sel),
        .pwr_dn   (pwr_dn)
    );

    function automatic logic [11:0] exp_load(input logic [7:0] ctrl,
                                             input logic [7:0] lo,
                                             input logic [7:0] hi);
        if (ctrl[3])
            return {lo, 4'h0};
        else
            return {hi[3:0], lo};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == A_CTRL) begin
            m_ctrl = {3'b000, d[4:0]};
            if (!m_ctrl[1]) begin
                m_low  = 8'h00;
                m_high = 8'h00;
                m_code = 12'h000;
            end
        end else if (a == A_LOW && m_ctrl[1]) begin
            m_low  = d;
            m_code = exp_load(m_ctrl, d, m_high);
        end else if (a == A_HIGH && m_ctrl[1]) begin
            m_high = d;
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_check(input string tag, input logic [7:0] a,
                              input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, "readback", {24'h0, bus_rdata}, {24'h0, exp});
    endtask

    task automatic check_outputs(input string tag);
        check(tag, "dac_code",  {20'h0, dac_code}, {20'h0, m_code});
        check(tag, "range_sel", {31'h0, range_sel}, {31'h0, m_ctrl[2]});
        check(tag, "pin_sel",   {31'h0, pin_sel},   {31'h0, m_ctrl[4]});
        check(tag, "pwr_dn",    {31'h0, pwr_dn},    {31'h0, ~m_ctrl[0]});
    endtask

    task automatic check_all(input string tag);
        check_outputs(tag);
        read_check(tag, A_LOW,  m_low);
        read_check(tag, A_HIGH, m_high);
        read_check(tag, A_CTRL, m_ctrl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_1234);

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R2: unmapped address write ignored and read as zero
        bus_write(8'h10, 8'hFF);
        check_all("R2");
        read_check("R2", 8'hFA, 8'h00);

        // R5: writes while run bit is 0 are ignored
        bus_write(A_HIGH, 8'hAB);
        bus_write(A_LOW, 8'hCD);
        check_all("R5");

        // R3/R4: control fields, reserved bits read 0
        bus_write(A_CTRL, 8'hF7);
        check_all("R3");
        check_outputs("R4");

        // R6: high write alone does not move the code
        bus_write(A_HIGH, 8'hF5);
        check_all("R6");

        // R7: 12-bit commit
        bus_write(A_LOW, 8'h3C);
        check_all("R7");
        check("R7", "code value", {20'h0, dac_code}, 32'h53C);

        // R10: mode flip alone leaves code
        bus_write(A_CTRL, 8'h0B);
        check_all("R10");
        check("R10", "code held", {20'h0, dac_code}, 32'h53C);

        // R8: 8-bit commit, bottom nibble zero
        bus_write(A_LOW, 8'hE9);
        check_all("R8");
        check("R8", "code value", {20'h0, dac_code}, 32'hE90);

        // R9: clear zeroes data and code
        bus_write(A_CTRL, 8'h09);
        check_all("R9");
        check("R9", "code zero", {20'h0, dac_code}, 32'h000);

        // R2: other addresses stay zero with data live
        bus_write(A_CTRL, 8'h03);
        bus_write(A_HIGH, 8'h0F);
        bus_write(8'hFE, 8'h55);
        check_all("R2");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            logic [7:0] d;
            int pick;
            pick = $urandom_range(0, 9);
            d = 8'($urandom());
            if (pick < 4)
                a = A_LOW;
            else if (pick < 7)
                a = A_HIGH;
            else if (pick < 9) begin
                a = A_CTRL;
                if ($urandom_range(0, 9) < 8)
                    d[1] = 1'b1;
            end else
                a = 8'($urandom());
            bus_write(a, d);
            if (a == A_CTRL && !d[1])
                check_all("R9");
            else if (a == A_LOW)
                check_all(m_ctrl[3] ? "R8" : "R7");
            else if (a == A_HIGH)
                check_all("R6");
            else if (a == A_CTRL)
                check_all("R3");
            else
                check_all("R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule